// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the datapath of a 32-bit load/store processor. Each instruction takes several clock cycles, and every cycle performs one step. The block has a single ALU and a single memory port, and every step uses them. Values that one step produces for a later step are kept in internal holding registers: the instruction register, two operand registers, the ALU result register and the memory data register. The block makes no sequencing decisions of its own. An external controller drives every register enable, mux select and the 2-bit ALU operation code. The datapath returns the opcode field of the current instruction and the ALU zero flag so that the controller can pick its next step.

A typical controller runs these steps. Fetch loads the instruction and stores PC+4 through the ALU in the same cycle. Decode reads the two source registers and, for every instruction, computes a possible branch target into the ALU result register. The step after that is one of: an address computation, an ALU operation, or a branch compare. Loads, stores and R-type instructions finish with a memory access step or a write-back step. A 32-entry register file and a word-addressed memory array are included, and a test environment can preload that array.

Top module: `mc_datapath`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises, the PC equals `RESET_PC` (default 0). The instruction, operand, ALU-result and memory-data registers are all zero, and so is every register-file entry.
- R2: The memory address comes from the PC when `iord`=0 and from the ALU result register when `iord`=1. The memory holds 32-bit words selected by address bits [AW+1:2]. Read data is zero when `mem_rd` is low. The instruction register loads the read data only on an edge where `ir_we` is high, and holds otherwise.
- R3: The PC loads on an edge where `pc_we` is high, or where `pc_cond_we` is high and the ALU result is zero. Otherwise it holds.
- R4: The PC source selection `pc_src` has these codes: 00 and 11 give the live ALU result, 01 gives the ALU result register, and 10 gives the jump target {PC[31:28], IR[25:0], 2'b00}.
- R5: On every edge, operand register A loads register-file entry IR[25:21] and operand register B loads entry IR[20:16].
- R6: The ALU result register and the memory data register load on every edge and have no enable.
- R7: ALU operand A is the PC when `src_a`=0 and register A when `src_a`=1. ALU operand B has four codes: `src_b`=00 gives register B, 01 gives the constant 4, 10 gives IR[15:0] sign-extended, and 11 gives that value shifted left by two.
- R8: The ALU operation code `alu_op` works as follows: 00 adds, 01 subtracts B from A, 10 decodes the function field IR[5:0], and 11 adds.
- R9: The function-field decode gives add for 0x20, subtract for 0x22, AND for 0x24, OR for 0x25, and signed set-less-than (1 or 0) for 0x2A. Every other code gives zero.
- R10: When `reg_we` is high, the register file is written on the edge. The destination is IR[15:11] when `reg_dst`=1 and IR[20:16] when `reg_dst`=0. The data is the memory data register when `mem_to_reg`=1 and the ALU result register when `mem_to_reg`=0.
- R11: Register 0 always reads as zero, and writes to it are dropped.
- R12: When `mem_wr` is high, register B is written on the edge to the memory word selected by the current address.
- R13: `opcode_o` shows IR[31:26]. `zero_o` is high exactly when the live ALU result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| iord | input | 1 | Memory address select: 0 PC, 1 ALU result register |
| mem_rd | input | 1 | Memory read enable |
| mem_wr | input | 1 | Memory write enable |
| ir_we | input | 1 | Instruction register load enable |
| pc_we | input | 1 | Unconditional PC write |
| pc_cond_we | input | 1 | PC write when the ALU result is zero |
| pc_src | input | 2 | PC next-value select |
| alu_op | input | 2 | ALU operation code |
| src_a | input | 1 | ALU operand A select |
| src_b | input | 2 | ALU operand B select |
| reg_we | input | 1 | Register file write enable |
| reg_dst | input | 1 | Destination field select |
| mem_to_reg | input | 1 | Write-back data select |
| opcode_o | output | 6 | Opcode field of the instruction register |
| zero_o | output | 1 | Live ALU result is zero |
| pc_o | output | 32 | Current PC |
| aluout_o | output | 32 | ALU result register |

## Verification
The bench builds the block with `MEM_WORDS`=64 and `RESET_PC`=0. In that small array, the program sits in the low words and the data sits in words 40 to 42. Instruction fetch and data access therefore share one port and one array, and a store followed by a load of the same word can be tested. The zero reset PC and the short program are enough to reach a taken branch, a branch that is not taken, a jump, and the end of the program within a few hundred cycles.

// File: rtl/mc_datapath.sv
module mc_datapath #(
  parameter int MEM_WORDS = 256,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        iord,
  input  logic        mem_rd,
  input  logic        mem_wr,
  input  logic        ir_we,
  input  logic        pc_we,
  input  logic        pc_cond_we,
  input  logic [1:0]  pc_src,
  input  logic [1:0]  alu_op,
  input  logic        src_a,
  input  logic [1:0]  src_b,
  input  logic        reg_we,
  input  logic        reg_dst,
  input  logic        mem_to_reg,
  output logic [5:0]  opcode_o,
  output logic        zero_o,
  output logic [31:0] pc_o,
  output logic [31:0] aluout_o
);
  localparam int AW = $clog2(MEM_WORDS);

  logic [31:0] pc, ir, ra, rb, alo, mdr;
  logic [31:0] rf [32];
  logic [31:0] mem [MEM_WORDS];

  logic [31:0] addr, rdata, imm, opa, opb, res, pc_next, wdata;
  logic [4:0]  wdst;
  logic        pc_load;

  assign addr  = iord ? alo : pc;
  assign rdata = mem_rd ? mem[addr[AW+1:2]] : 32'h0;
  assign imm   = {{16{ir[15]}}, ir[15:0]};
  assign opa   = src_a ? ra : pc;

  always_comb begin
    case (src_b)
      2'b00:   opb = rb;
      2'b01:   opb = 32'd4;
      2'b10:   opb = imm;
      default: opb = {imm[29:0], 2'b00};
    endcase
  end

  always_comb begin
    case (alu_op)
      2'b01: res = opa - opb;
      2'b10: begin
        case (ir[5:0])
          6'h20:   res = opa + opb;
          6'h22:   res = opa - opb;
          6'h24:   res = opa & opb;
          6'h25:   res = opa | opb;
          6'h2a:   res = {31'h0, $signed(opa) < $signed(opb)};
          default: res = 32'h0;
        endcase
      end
      default: res = opa + opb;
    endcase
  end

  assign zero_o = (res == 32'h0);

  always_comb begin
    case (pc_src)
      2'b01:   pc_next = alo;
      2'b10:   pc_next = {pc[31:28], ir[25:0], 2'b00};
      default: pc_next = res;
    endcase
  end

  assign pc_load = pc_we | (pc_cond_we & zero_o);
  assign wdst    = reg_dst ? ir[15:11] : ir[20:16];
  assign wdata   = mem_to_reg ? mdr : alo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc  <= RESET_PC;
      ir  <= '0;
      ra  <= '0;
      rb  <= '0;
      alo <= '0;
      mdr <= '0;
    end else begin
      if (pc_load) pc <= pc_next;
      if (ir_we)   ir <= rdata;
      ra  <= rf[ir[25:21]];
      rb  <= rf[ir[20:16]];
      alo <= res;
      mdr <= rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else if (reg_we && wdst != 5'd0) begin
      rf[wdst] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && mem_wr) mem[addr[AW+1:2]] <= rb;
  end

  assign opcode_o = ir[31:26];
  assign pc_o     = pc;
  assign aluout_o = alo;

  assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_we && !(pc_cond_we && zero_o)) |=> $stable(pc_o));

  assert_branch_not_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_cond_we && !pc_we && !zero_o) |=> $stable(pc_o));

  assert_ir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_we |=> $stable(opcode_o));

  assert_r0_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rf[0] == 32'h0);

  assert_rf_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && wdst != 5'd0) |=> rf[$past(wdst)] == $past(wdata));

endmodule

// File: tb/mc_datapath_bench.sv
module mc_datapath_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iord, mem_rd, mem_wr, ir_we, pc_we, pc_cond_we, src_a, reg_we, reg_dst, mem_to_reg;
  logic [1:0] pc_src, alu_op, src_b;
  logic [5:0] opcode_o;
  logic zero_o;
  logic [31:0] pc_o, aluout_o;

  int total = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] m_pc, m_ir, m_a, m_b, m_alo, m_mdr;
  logic [31:0] m_rf [32];
  logic [31:0] m_mem [64];

  always #10 clk = ~clk;

  mc_datapath #(.MEM_WORDS(64), .RESET_PC(32'h0)) u_mc_datapath (
    .clk(clk), .rst_n(rst_n), .iord(iord), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .ir_we(ir_we), .pc_we(pc_we), .pc_cond_we(pc_cond_we), .pc_src(pc_src),
    .alu_op(alu_op), .src_a(src_a), .src_b(src_b), .reg_we(reg_we),
    .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .opcode_o(opcode_o),
    .zero_o(zero_o), .pc_o(pc_o), .aluout_o(aluout_o));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rtype(int rs, int rt, int rd, logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] itype(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] ref_alu(logic [31:0] x, logic [31:0] y, logic [1:0] op, logic [5:0] fn);
    if (op == 2'b01) return x - y;
    if (op != 2'b10) return x + y;
    case (fn)
      6'h20: return x + y;
      6'h22: return x - y;
      6'h24: return x & y;
      6'h25: return x | y;
      6'h2a: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic idle();
    {iord, mem_rd, mem_wr, ir_we, pc_we, pc_cond_we, src_a, reg_we, reg_dst, mem_to_reg} = '0;
    pc_src = 2'b00; alu_op = 2'b00; src_b = 2'b00;
  endtask

  task automatic tick(string tag);
    logic [31:0] x, y, imm, res, addr, rd, npc;
    logic [4:0] dst;
    logic z;
    #1;
    imm = {{16{m_ir[15]}}, m_ir[15:0]};
    x = src_a ? m_a : m_pc;
    case (src_b)
      2'b00: y = m_b;
      2'b01: y = 4;
      2'b10: y = imm;
      default: y = imm << 2;
    endcase
    res = ref_alu(x, y, alu_op, m_ir[5:0]);
    z = (res == 0);
    chk({tag, " R13 zero"}, {31'h0, zero_o}, {31'h0, z});
    addr = iord ? m_alo : m_pc;
    rd = mem_rd ? m_mem[addr[7:2]] : 32'h0;
    npc = (pc_src == 2'b01) ? m_alo : (pc_src == 2'b10) ? {m_pc[31:28], m_ir[25:0], 2'b00} : res;
    dst = reg_dst ? m_ir[15:11] : m_ir[20:16];
    @(posedge clk);
    if (reg_we && dst != 0) m_rf[dst] = mem_to_reg ? m_mdr : m_alo;
    if (mem_wr) m_mem[addr[7:2]] = m_b;
    if (pc_we || (pc_cond_we && z)) m_pc = npc;
    m_a = m_rf[m_ir[25:21]];
    m_b = m_rf[m_ir[20:16]];
    if (ir_we) m_ir = rd;
    m_alo = res;
    m_mdr = rd;
    @(negedge clk);
    chk({tag, " pc"}, pc_o, m_pc);
    chk({tag, " aluout"}, aluout_o, m_alo);
    chk({tag, " R13 opcode"}, {26'h0, opcode_o}, {26'h0, m_ir[31:26]});
    idle();
  endtask

  task automatic fetch();
    mem_rd = 1; ir_we = 1; pc_we = 1; src_b = 2'b01;
    tick("R2 R3 R4 fetch");
  endtask

  task automatic decode();
    src_b = 2'b11;
    tick("R5 R7 decode");
  endtask

  task automatic do_rtype(string tag);
    fetch(); decode();
    src_a = 1; alu_op = 2'b10; tick({tag, " R8 R9 exec"});
    reg_we = 1; reg_dst = 1; tick({tag, " R10 writeback"});
    src_a = 1; tick({tag, " R6 idle"});
  endtask

  task automatic do_load(string tag, bit rd_en);
    fetch(); decode();
    src_a = 1; src_b = 2'b10; tick({tag, " R7 addr"});
    iord = 1; mem_rd = rd_en; tick({tag, " R2 R6 mem"});
    reg_we = 1; mem_to_reg = 1; tick({tag, " R10 load wb"});
  endtask

  task automatic do_store();
    fetch(); decode();
    src_a = 1; src_b = 2'b10; tick("R7 store addr");
    iord = 1; mem_wr = 1; tick("R12 store");
  endtask

  task automatic do_beq(string tag);
    fetch(); decode();
    src_a = 1; alu_op = 2'b01; pc_cond_we = 1; pc_src = 2'b01; tick({tag, " R3 R4 beq"});
  endtask

  initial begin
    for (int i = 0; i < 64; i++) m_mem[i] = 32'h0;
    m_mem[0]  = itype(6'h23, 0, 1, 160);
    m_mem[1]  = itype(6'h23, 0, 2, 164);
    m_mem[2]  = rtype(1, 2, 3, 6'h20);
    m_mem[3]  = rtype(1, 2, 4, 6'h22);
    m_mem[4]  = rtype(1, 2, 5, 6'h24);
    m_mem[5]  = rtype(1, 2, 6, 6'h25);
    m_mem[6]  = rtype(2, 1, 7, 6'h2a);
    m_mem[7]  = rtype(1, 2, 8, 6'h2a);
    m_mem[8]  = rtype(1, 1, 0, 6'h20);
    m_mem[9]  = itype(6'h2b, 0, 3, 168);
    m_mem[10] = itype(6'h23, 0, 9, 168);
    m_mem[11] = itype(6'h04, 1, 2, 5);
    m_mem[12] = itype(6'h04, 3, 9, 2);
    m_mem[15] = {6'h02, 26'd20};
    m_mem[20] = rtype(1, 1, 10, 6'h07);
    m_mem[21] = itype(6'h23, 0, 11, 160);
    m_mem[22] = rtype(1, 2, 12, 6'h20);
    m_mem[40] = 32'd7;
    m_mem[41] = 32'hFFFF_FFFD;
    for (int i = 0; i < 64; i++) u_mc_datapath.mem[i] = m_mem[i];
    for (int i = 0; i < 32; i++) m_rf[i] = 32'h0;
    {m_pc, m_ir, m_a, m_b, m_alo, m_mdr} = '0;
    idle();
    repeat (3) @(negedge clk);
    chk("R1 reset pc", pc_o, 32'h0);
    chk("R1 reset aluout", aluout_o, 32'h0);
    chk("R1 reset opcode", {26'h0, opcode_o}, 32'h0);
    rst_n = 1'b1;
    tick("R1 R6 first idle");
    do_load("R2 load r1", 1);
    do_load("R2 load r2", 1);
    do_rtype("R9 add");
    do_rtype("R9 sub");
    do_rtype("R9 and");
    do_rtype("R9 or");
    do_rtype("R9 slt true");
    do_rtype("R9 slt false");
    do_rtype("R11 write r0");
    do_store();
    do_load("R12 reload", 1);
    do_beq("not taken");
    chk("R3 untaken pc", pc_o, 32'd48);
    do_beq("taken");
    chk("R3 taken pc", pc_o, 32'd60);
    fetch(); decode();
    pc_we = 1; pc_src = 2'b10; tick("R4 jump");
    chk("R4 jump pc", pc_o, 32'd80);
    do_rtype("R9 unknown funct");
    do_load("R2 read disabled", 0);
    fetch(); decode();
    src_a = 1; alu_op = 2'b11; tick("R8 op11 adds");
    chk("R8 op11 sum", aluout_o, 32'd4);
    pc_we = 1; pc_src = 2'b11; src_b = 2'b01; tick("R4 src11");
    chk("R4 src11 pc", pc_o, 32'd96);
    src_a = 1; decode();
    chk("R10 r3 sum", m_rf[3], 32'd4);
    chk("R11 r0", m_rf[0], 32'd0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule